// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the target side of a two-wire serial memory bus, backed by a byte array built from on-chip registers. It samples the clock and data lines with the system clock and finds bus start and stop events. It compares the select byte with three strap inputs and takes a two-byte word address. It then either collects write data or returns read data, and it moves an internal address pointer after every byte. SDA is driven only through an open-drain enable: while `sda_oe` is high the line is pulled low.

Write data goes into a page staging buffer first. It reaches the array only when a stop event closes the command. A programming interval of `PROG_CYCLES` clock cycles then starts, and during it the device ignores the bus and raises `busy`. A write-protect input lets the select and address phases run normally but refuses every data byte. The array depth is set by `ADDR_W`. The default of 11 gives 2048 bytes, and 13 gives the full 8192-byte configuration. Pages are `2**PAGE_W` bytes, 32 by default.

Top module: `i2c_eeprom`

## Requirements
- R1: A select byte is received MSB first. The device acknowledges it by pulling SDA low during the 9th clock only when bits 7..4 are 1010 and bits 3..1 equal `ce[2:0]`. Bit 0 selects read (1) or write (0). On a mismatch the device stays silent until the next start.
- R2: Start is SDA falling while SCL is high, and stop is SDA rising while SCL is high. A byte clocked in without a preceding start gets no acknowledge. The device changes its SDA drive only while SCL is low.
- R3: The word address arrives as a high byte and then a low byte, and both are acknowledged. Only the low `ADDR_W` bits of the 16 received bits are used.
- R4: A write of one data byte followed by stop stores that byte at the addressed location.
- R5: In a page write, each data byte is stored at the current address, and then only the low `PAGE_W` address bits advance. Data wraps inside the page, and a later byte overwrites an earlier one at the same offset.
- R6: Buffered write data is committed only at stop. A start before that stop discards it. A committing stop raises `busy` for exactly `PROG_CYCLES` cycles.
- R7: While `busy` is high the device acknowledges nothing and never drives SDA.
- R8: A random read (write select, address, repeated start, read select) returns the byte at that address.
- R9: A read select issued directly after start returns the byte that follows the last byte read.
- R10: In a sequential read the address advances after every byte and rolls over from the top address to 0.
- R11: When the master does not acknowledge a read byte, the device releases SDA and does nothing more until a stop or start.
- R12: While `wc` is high, select and address bytes are acknowledged. Data bytes get no acknowledge, leave the array unchanged and start no programming interval.
- R13: After reset `sda_oe` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull SDA low when high |
| ce | input | 3 | Chip-enable straps matched against select bits 3..1 |
| wc | input | 1 | Write protect, high refuses data bytes |
| busy | output | 1 | Programming interval in progress |

## Verification
The programming interval and a new command can meet in time. The stop that commits a write arms the timer in the same cycle that the bus becomes free again. The bench provokes this by sending a start and a read select at once after that stop. It expects no acknowledge while `busy` stays high. Once `busy` falls, a random read of the same address must return the new byte, and the measured `busy` length must equal `PROG_CYCLES`.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_ADH,
        S_ADL,
        S_WR,
        S_ACK,
        S_TX,
        S_TXACK,
        S_WAIT
    } eep_state_e;

    // Bus events derived from the sampled lines.
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
        logic scl;
    } bus_ev_t;

    function automatic logic sel_match(input logic [7:0] b, input logic [2:0] straps);
        return (b[7:4] == DEV_CODE) && (b[3:1] == straps);
    endfunction

endpackage

// File: rtl/eep_line_sense.sv
module eep_line_sense
    import eep_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic scl_m, scl_s, scl_q;
    logic sda_m, sda_s, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_m <= 1'b1; scl_s <= 1'b1; scl_q <= 1'b1;
            sda_m <= 1'b1; sda_s <= 1'b1; sda_q <= 1'b1;
        end else begin
            scl_m <= scl_in; scl_s <= scl_m; scl_q <= scl_s;
            sda_m <= sda_in; sda_s <= sda_m; sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.scl   = scl_s;
        ev.sda   = sda_s;
        ev.rise  = scl_s & ~scl_q;
        ev.fall  = ~scl_s & scl_q;
        ev.start = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [7:0]                   wr_data,
    output logic [(1<<PAGE_W)-1:0][7:0]  pdata,
    output logic [(1<<PAGE_W)-1:0]       pmask,
    output logic [ADDR_W-PAGE_W-1:0]     ppage
);
    localparam int PAGE = 1 << PAGE_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            ppage <= '0;
        end else if (wr_en) begin
            ppage <= wr_addr[ADDR_W-1:PAGE_W];
        end
    end

    for (genvar g = 0; g < PAGE; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                pmask[g] <= 1'b0;
                pdata[g] <= '0;
            end else if (wr_en && wr_addr[PAGE_W-1:0] == PAGE_W'(g)) begin
                pmask[g] <= 1'b1;
                pdata[g] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         commit,
    input  logic [ADDR_W-PAGE_W-1:0]     ppage,
    input  logic [(1<<PAGE_W)-1:0][7:0]  pdata,
    input  logic [(1<<PAGE_W)-1:0]       pmask,
    input  logic [ADDR_W-1:0]            raddr,
    output logic [7:0]                   rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << PAGE_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (commit) begin
            for (int i = 0; i < PAGE; i++) begin
                if (pmask[i]) mem[{ppage, PAGE_W'(i)}] <= pdata[i];
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            left <= '0;
        end else if (go && !busy) begin
            busy <= 1'b1;
            left <= CW'(PROG_CYCLES - 1);
        end else if (busy) begin
            if (left == '0) busy <= 1'b0;
            else            left <= left - 1'b1;
        end
    end
endmodule

// File: rtl/eep_proto.sv
module eep_proto
    import eep_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  bus_ev_t           ev,
    input  logic [2:0]        ce,
    input  logic              wc,
    input  logic [7:0]        rdata,
    output logic [ADDR_W-1:0] addr,
    output logic              sda_oe,
    output logic              buf_clear,
    output logic              buf_wr,
    output logic [7:0]        buf_data
);
    eep_state_e       state, nxt;
    logic [3:0]       bitn;
    logic [7:0]       sh;
    logic [6:0]       txsh;
    logic [ADDR_W-9:0] hi_q;
    logic             mack;
    logic             byte_end;

    assign byte_end  = ev.fall && (bitn == 4'd8);
    assign buf_clear = ev.start && !hold;
    assign buf_wr    = (state == S_WR) && byte_end && !wc && !hold && !ev.start && !ev.stop;
    assign buf_data  = sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            nxt    <= S_IDLE;
            bitn   <= '0;
            sh     <= '0;
            txsh   <= '0;
            hi_q   <= '0;
            addr   <= '0;
            mack   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (hold) begin
            state  <= S_IDLE;
            bitn   <= '0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            state  <= S_IDLE;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            state  <= S_DEV;
            bitn   <= '0;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                S_DEV, S_ADH, S_ADL, S_WR: begin
                    if (ev.rise && bitn != 4'd8) begin
                        sh   <= {sh[6:0], ev.sda};
                        bitn <= bitn + 1'b1;
                    end else if (byte_end) begin
                        bitn <= '0;
                        unique case (state)
                            S_DEV: begin
                                if (sel_match(sh, ce)) begin
                                    sda_oe <= 1'b1;
                                    state  <= S_ACK;
                                    nxt    <= sh[0] ? S_TX : S_ADH;
                                end else begin
                                    state <= S_WAIT;
                                end
                            end
                            S_ADH: begin
                                hi_q   <= sh[ADDR_W-9:0];
                                sda_oe <= 1'b1;
                                state  <= S_ACK;
                                nxt    <= S_ADL;
                            end
                            S_ADL: begin
                                addr   <= {hi_q, sh};
                                sda_oe <= 1'b1;
                                state  <= S_ACK;
                                nxt    <= S_WR;
                            end
                            default: begin
                                if (wc) begin
                                    state <= S_WAIT;
                                end else begin
                                    addr   <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
                                    sda_oe <= 1'b1;
                                    state  <= S_ACK;
                                    nxt    <= S_WR;
                                end
                            end
                        endcase
                    end
                end
                S_ACK: begin
                    if (ev.fall) begin
                        state  <= nxt;
                        bitn   <= '0;
                        sda_oe <= 1'b0;
                        if (nxt == S_TX) begin
                            txsh   <= rdata[6:0];
                            sda_oe <= ~rdata[7];
                        end
                    end
                end
                S_TX: begin
                    if (ev.fall) begin
                        if (bitn == 4'd7) begin
                            sda_oe <= 1'b0;
                            state  <= S_TXACK;
                            addr   <= addr + 1'b1;
                        end else begin
                            sda_oe <= ~txsh[6];
                            txsh   <= {txsh[5:0], 1'b0};
                            bitn   <= bitn + 1'b1;
                        end
                    end
                end
                S_TXACK: begin
                    if (ev.rise) begin
                        mack <= ~ev.sda;
                    end else if (ev.fall) begin
                        if (mack) begin
                            txsh   <= rdata[6:0];
                            sda_oe <= ~rdata[7];
                            bitn   <= '0;
                            state  <= S_TX;
                        end else begin
                            state <= S_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_eeprom.sv
module i2c_eeprom
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 5,
    parameter int PROG_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic [2:0] ce,
    input  logic       wc,
    output logic       busy
);
    localparam int PAGE = 1 << PAGE_W;

    bus_ev_t                    ev;
    logic [ADDR_W-1:0]          addr;
    logic [7:0]                 rdata;
    logic                       buf_clear, buf_wr, go;
    logic [7:0]                 buf_data;
    logic [PAGE-1:0][7:0]       pdata;
    logic [PAGE-1:0]            pmask;
    logic [ADDR_W-PAGE_W-1:0]   ppage;
    logic                       scl_sync, stop_evt;

    assign scl_sync = ev.scl;
    assign stop_evt = ev.stop;
    assign go       = ev.stop && !busy && (|pmask);

    eep_line_sense u_sense (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    eep_proto #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_proto (
        .clk(clk), .rst(rst), .hold(busy), .ev(ev), .ce(ce), .wc(wc),
        .rdata(rdata), .addr(addr), .sda_oe(sda_oe),
        .buf_clear(buf_clear), .buf_wr(buf_wr), .buf_data(buf_data)
    );

    eep_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_buf (
        .clk(clk), .rst(rst), .clear(buf_clear || go), .wr_en(buf_wr),
        .wr_addr(addr), .wr_data(buf_data),
        .pdata(pdata), .pmask(pmask), .ppage(ppage)
    );

    eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
        .clk(clk), .rst(rst), .commit(go), .ppage(ppage), .pdata(pdata),
        .pmask(pmask), .raddr(addr), .rdata(rdata)
    );

    eep_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .go(go), .busy(busy)
    );
endmodule

// File: rtl/eep_checker.sv
module eep_checker #(
    parameter int PROG_CYCLES = 1000
) (
    input logic clk,
    input logic rst,
    input logic sda_oe,
    input logic busy,
    input logic scl_sync,
    input logic stop_seen
);
    int run;

    always_ff @(posedge clk) begin
        if (rst)       run <= 0;
        else if (busy) run <= run + 1;
        else           run <= 0;
    end

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe); // R7

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_sync); // R2

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run == PROG_CYCLES)); // R6

    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_seen)); // R6
endmodule

bind i2c_eeprom eep_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .sda_oe(sda_oe), .busy(busy),
    .scl_sync(scl_sync), .stop_seen(stop_evt)
);

// File: tb/i2c_eeprom_tb.sv
module i2c_eeprom_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 11;
    localparam int PAGE_W     = 5;
    localparam int PROG       = 1000;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int Q          = 8;
    localparam logic [2:0] CE = 3'b101;

    logic clk = 0, rst = 1, scl_m = 1, sda_m = 1, wc = 0;
    logic sda_oe, busy, sda_line;
    logic [7:0] model [DEPTH];
    int checks = 0, errors = 0, run = 0, last_len = 0;
    bit done = 0;

    assign sda_line = sda_m & ~sda_oe;

    i2c_eeprom #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG)) u_dut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .ce(CE), .wc(wc), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (busy) run++;
        else begin
            if (run != 0) last_len = run;
            run = 0;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1; wq(Q); scl_m = 1; wq(Q); b = sda_line; wq(Q); scl_m = 0; wq(Q);
    endtask

    task automatic bus_start();
        sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(a);
        ack = ~a;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) bit_in(d[i]);
        bit_out(~give_ack);
    endtask

    function automatic logic [7:0] sel(input logic rw);
        return {4'b1010, CE, rw};
    endfunction

    task automatic wait_ready();
        int g = 0;
        while (busy && g < 5000) begin wq(1); g++; end
        wq(4);
    endtask

    task automatic write_seq(input logic [15:0] a, input int n,
                             input logic [7:0] first, input logic [7:0] step);
        logic ack;
        logic [ADDR_W-1:0] ae;
        ae = a[ADDR_W-1:0];
        bus_start();
        send_byte(sel(1'b0), ack); chk("R1 select ack", ack, 1);
        send_byte(a[15:8], ack);   chk("R3 high address ack", ack, 1);
        send_byte(a[7:0], ack);    chk("R3 low address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            logic [PAGE_W-1:0] off;
            d   = first + 8'(i) * step;
            off = ae[PAGE_W-1:0] + PAGE_W'(i);
            send_byte(d, ack);
            chk("R5 data ack", ack, 1);
            model[{ae[ADDR_W-1:PAGE_W], off}] = d;
        end
        bus_stop();
        wait_ready();
        chk("R6 busy length", last_len, PROG);
    endtask

    task automatic read_seq(input logic [15:0] a, input int n, input string req);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(sel(1'b0), ack);
        send_byte(a[15:8], ack);
        send_byte(a[7:0], ack);
        bus_start();
        send_byte(sel(1'b1), ack); chk("R8 read select ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, d);
            chk(req, d, model[(int'(a[ADDR_W-1:0]) + i) % DEPTH]);
        end
        bus_stop();
        wq(Q);
    endtask

    task automatic t_reset();
        chk("R13 sda_oe after reset", sda_oe, 0);
        chk("R13 busy after reset", busy, 0);
    endtask

    task automatic t_byte_write();
        write_seq(16'h0123, 1, 8'h3C, 8'h00);
        read_seq(16'h0123, 1, "R4 byte write readback");
    endtask

    task automatic t_high_bits_ignored();
        write_seq(16'hFC12, 1, 8'h9E, 8'h00);
        read_seq(16'h0412, 1, "R3 upper address bits ignored");
    endtask

    task automatic t_page_wrap();
        write_seq(16'h00BC, 34, 8'h40, 8'h03);
        read_seq(16'h00A0, 32, "R5 page wrap and overwrite");
    endtask

    task automatic t_rollover();
        write_seq(16'h07FE, 2, 8'hE1, 8'h01);
        write_seq(16'h0000, 2, 8'h71, 8'h01);
        read_seq(16'h07FE, 4, "R10 sequential rollover");
    endtask

    task automatic t_current_read();
        logic ack;
        logic [7:0] d;
        write_seq(16'h0124, 1, 8'hD7, 8'h00);
        read_seq(16'h0123, 1, "R8 random read");
        bus_start();
        send_byte(sel(1'b1), ack); chk("R9 current read select ack", ack, 1);
        recv_byte(1'b0, d);
        chk("R9 current address read", d, model[12'h124]);
        bus_stop(); wq(Q);
    endtask

    task automatic t_wrong_select();
        logic ack;
        bus_start();
        send_byte({4'b1010, 3'b010, 1'b0}, ack); chk("R1 mismatched straps no ack", ack, 0);
        send_byte(8'h01, ack);                   chk("R1 silent after mismatch", ack, 0);
        bus_stop(); wq(Q);
        bus_start();
        send_byte({4'b0110, CE, 1'b1}, ack);     chk("R1 wrong device code no ack", ack, 0);
        bus_stop(); wq(Q);
    endtask

    task automatic t_no_start();
        logic ack;
        scl_m = 0; wq(Q);
        send_byte(sel(1'b1), ack); chk("R2 no ack without start", ack, 0);
        bus_stop(); wq(Q);
    endtask

    task automatic t_write_protect();
        logic ack;
        wc = 1;
        bus_start();
        send_byte(sel(1'b0), ack); chk("R12 select ack under wc", ack, 1);
        send_byte(8'h01, ack);     chk("R12 high address ack under wc", ack, 1);
        send_byte(8'h23, ack);     chk("R12 low address ack under wc", ack, 1);
        send_byte(8'hA5, ack);     chk("R12 data refused under wc", ack, 0);
        bus_stop(); wq(20);
        chk("R12 no programming under wc", busy, 0);
        wc = 0;
        read_seq(16'h0123, 1, "R12 array unchanged under wc");
    endtask

    task automatic t_restart_discard();
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(sel(1'b0), ack);
        send_byte(8'h02, ack); send_byte(8'h00, ack);
        send_byte(8'h99, ack); chk("R6 data ack before restart", ack, 1);
        bus_start();
        send_byte(sel(1'b0), ack);
        send_byte(8'h02, ack); send_byte(8'h00, ack);
        bus_start();
        send_byte(sel(1'b1), ack);
        recv_byte(1'b0, d);
        bus_stop(); wq(20);
        chk("R6 restart discards buffered data", d, model[12'h200]);
        chk("R6 no programming after discard", busy, 0);
    endtask

    task automatic t_lockout();
        logic ack;
        bus_start();
        send_byte(sel(1'b0), ack);
        send_byte(8'h03, ack); send_byte(8'h00, ack);
        send_byte(8'h66, ack);
        model[12'h300] = 8'h66;
        bus_stop();
        chk("R6 busy raised by committing stop", busy, 1);
        bus_start();
        send_byte(sel(1'b1), ack); chk("R7 no ack while busy", ack, 0);
        chk("R7 still busy during attempt", busy, 1);
        bus_stop();
        wait_ready();
        chk("R6 busy length after lockout", last_len, PROG);
        read_seq(16'h0300, 1, "R7 committed data after lockout");
    endtask

    task automatic t_master_nack();
        logic ack, b;
        logic [7:0] d;
        int lows = 0;
        bus_start();
        send_byte(sel(1'b0), ack);
        send_byte(8'h01, ack); send_byte(8'h23, ack);
        bus_start();
        send_byte(sel(1'b1), ack);
        recv_byte(1'b0, d);
        chk("R11 byte before nack", d, model[12'h123]);
        for (int i = 0; i < 9; i++) begin
            bit_in(b);
            if (!b) lows++;
        end
        chk("R11 released after nack", lows, 0);
        bus_stop(); wq(Q);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        wq(5);
        rst = 0;
        wq(5);
        t_reset();
        t_byte_write();
        t_high_bits_ignored();
        t_page_wrap();
        t_rollover();
        t_current_read();
        t_wrong_select();
        t_no_start();
        t_write_protect();
        t_restart_discard();
        t_lockout();
        t_master_nack();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule